// File: doc/BRIEF.md
# Display Window and Orientation Command Generator

This block turns a request to draw into a pixel rectangle into the byte stream that a small TFT panel controller expects over a 9-bit serial link. Each output word is nine bits wide. Bit 8 is the data/command flag: 0 marks a command byte and 1 marks a parameter byte. Bits 7:0 carry the byte.

A request is a one-cycle `start` pulse. It comes with start and end coordinates for the two axes, a 2-bit rotation code and a blue-green-red order flag. The generator first emits a memory access control command when it is needed. It then emits the column window, the row window and a memory write command. The pixel data that follows belongs to a different block. Output words use a valid/ready handshake, `busy` covers the whole burst, and `done` marks the end of the burst.

The panel measures 176 by 220 pixels in its native orientation. When a rotation swaps the axes, the limits swap with them. Coordinates past the last pixel are clamped to the last pixel.

Top module: `lcdWindowCmdGen`

## Requirements
- R1: After reset, `busy`, `wordValid` and `done` are all 0.
- R2: Bit 8 of `word` is 0 for every command byte and 1 for every parameter byte.
- R3: The column window is the command 0x2A followed by four parameters: 0x00, clamped xs, 0x00, clamped xe.
- R4: The row window comes right after the column window. It is the command 0x2B followed by 0x00, clamped ys, 0x00, clamped ye.
- R5: The last word of every burst is the memory write command 0x2C, and it has no parameters.
- R6: The orientation command is 0x36 followed by one parameter byte. In that byte, bit 7 is the row mirror, bit 6 is the column mirror, bit 5 is axis exchange and bit 3 equals `bgr`. All other bits are 0.
- R7: Rotation code 0 sets none of bits 7, 6 and 5. Code 1 sets bits 7 and 5. Code 2 sets bits 7 and 6. Code 3 sets bits 6 and 5.
- R8: The orientation command opens the burst on the first request after reset, and on any request whose `rot` or `bgr` differs from the values last sent. Otherwise it is left out, and the burst is 11 words long instead of 13.
- R9: X coordinates are clamped to 175 and y coordinates to 219 for rotation codes 0 and 2. For codes 1 and 3 the limits are 219 for x and 175 for y.
- R10: A `start` pulse that arrives while `busy` is 1 has no effect. It neither changes the burst in progress nor causes a later burst.
- R11: While `wordValid` is 1 and `wordReady` is 0, `word` and `wordValid` hold their values.
- R12: `done` is 1 for exactly one cycle, in the cycle after the 0x2C word is accepted. `busy` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled only when idle |
| xs | input | 8 | Window start column |
| ys | input | 8 | Window start row |
| xe | input | 8 | Window end column |
| ye | input | 8 | Window end row |
| rot | input | 2 | Rotation code, 0 to 3 |
| bgr | input | 1 | Blue-green-red colour order |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| wordValid | output | 1 | Output word valid |
| wordReady | input | 1 | Sink accepts the word |
| word | output | 9 | {data flag, byte} |

## Verification
`busy` and `wordValid` rise one cycle after the edge that samples `start`. Each later word appears one cycle after the edge that accepts the word before it. `done` rises one cycle after the edge that accepts 0x2C, and it falls one cycle after that. The bench drives inputs on falling edges and samples outputs on the following falling edges. It therefore reads each word, and `done`, exactly half a cycle after the edge that produced them. It also stalls `wordReady` in a pattern, so stable-hold is checked on the next sample.

// File: rtl/lcdWinPkg.sv
package lcdWinPkg;
  localparam int STEP_W = 4;
  localparam logic [STEP_W-1:0] STEP_ORIENT = 4'd0;
  localparam logic [STEP_W-1:0] STEP_COLWIN = 4'd2;
  localparam logic [STEP_W-1:0] STEP_LAST = 4'd12;

  localparam logic [7:0] OP_ORIENT = 8'h36;
  localparam logic [7:0] OP_COLWIN = 8'h2A;
  localparam logic [7:0] OP_ROWWIN = 8'h2B;
  localparam logic [7:0] OP_MEMWR = 8'h2C;

  typedef struct packed {
    logic load;
    logic [STEP_W-1:0] step;
  } ctrlStrobes_t;
endpackage

// File: rtl/lcdWinDatapath.sv
module lcdWinDatapath
  import lcdWinPkg::*;
#(
  parameter int COORD_W = 8,
  parameter int PANEL_W = 176,
  parameter int PANEL_H = 220
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       ctrl,
  input  logic [COORD_W-1:0] xs,
  input  logic [COORD_W-1:0] ys,
  input  logic [COORD_W-1:0] xe,
  input  logic [COORD_W-1:0] ye,
  input  logic [1:0]         rot,
  input  logic               bgr,
  output logic               needOrient,
  output logic [8:0]         word
);
  localparam logic [COORD_W-1:0] NAT_XMAX = COORD_W'(PANEL_W - 1);
  localparam logic [COORD_W-1:0] NAT_YMAX = COORD_W'(PANEL_H - 1);

  logic [COORD_W-1:0] coordIn [4];
  logic [COORD_W-1:0] coordClamped [4];
  logic [COORD_W-1:0] coordReg [4];
  logic [COORD_W-1:0] xMax, yMax;
  logic [1:0] rotReg, lastRot;
  logic bgrReg, lastBgr, orientSent;
  logic [7:0] orientParam;

  // rotation codes 1 and 3 exchange the axes
  assign xMax = rot[0] ? NAT_YMAX : NAT_XMAX;
  assign yMax = rot[0] ? NAT_XMAX : NAT_YMAX;

  assign coordIn[0] = xs;
  assign coordIn[1] = xe;
  assign coordIn[2] = ys;
  assign coordIn[3] = ye;

  for (genvar g = 0; g < 4; g++) begin : gClamp
    localparam bit IS_X = (g < 2);
    always_comb begin
      if (IS_X) coordClamped[g] = (coordIn[g] > xMax) ? xMax : coordIn[g];
      else      coordClamped[g] = (coordIn[g] > yMax) ? yMax : coordIn[g];
    end
    always_ff @(posedge clk) begin
      if (!rstN) coordReg[g] <= '0;
      else if (ctrl.load) coordReg[g] <= coordClamped[g];
    end
  end

  assign needOrient = !orientSent || (rot != lastRot) || (bgr != lastBgr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rotReg <= '0;
      bgrReg <= 1'b0;
      lastRot <= '0;
      lastBgr <= 1'b0;
      orientSent <= 1'b0;
    end else if (ctrl.load) begin
      rotReg <= rot;
      bgrReg <= bgr;
      lastRot <= rot;
      lastBgr <= bgr;
      orientSent <= 1'b1;
    end
  end

  always_comb begin
    unique case (rotReg)
      2'd0: orientParam = 8'h00;
      2'd1: orientParam = 8'hA0;
      2'd2: orientParam = 8'hC0;
      default: orientParam = 8'h60;
    endcase
    orientParam[3] = bgrReg;
  end

  always_comb begin
    unique case (ctrl.step)
      4'd0: word = {1'b0, OP_ORIENT};
      4'd1: word = {1'b1, orientParam};
      4'd2: word = {1'b0, OP_COLWIN};
      4'd4: word = {1'b1, 8'(coordReg[0])};
      4'd6: word = {1'b1, 8'(coordReg[1])};
      4'd7: word = {1'b0, OP_ROWWIN};
      4'd9: word = {1'b1, 8'(coordReg[2])};
      4'd11: word = {1'b1, 8'(coordReg[3])};
      4'd12: word = {1'b0, OP_MEMWR};
      default: word = {1'b1, 8'h00};
    endcase
  end

  assert_clamp_x_R9: assert property (@(posedge clk) disable iff (!rstN)
    rotReg[0] == 1'b0 |-> (coordReg[0] <= NAT_XMAX && coordReg[1] <= NAT_XMAX));
  assert_clamp_y_R9: assert property (@(posedge clk) disable iff (!rstN)
    rotReg[0] == 1'b0 |-> (coordReg[2] <= NAT_YMAX && coordReg[3] <= NAT_YMAX));
  assert_no_load_keeps_window_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> ($stable(coordReg[0]) && $stable(coordReg[3]) && $stable(rotReg)));
endmodule

// File: rtl/lcdWinControl.sv
module lcdWinControl
  import lcdWinPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         needOrient,
  input  logic         wordReady,
  output ctrlStrobes_t ctrl,
  output logic         busy,
  output logic         done
);
  logic [STEP_W-1:0] stepReg;
  logic accept;

  assign accept = busy && wordReady;
  assign ctrl.load = start && !busy;
  assign ctrl.step = stepReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
      stepReg <= '0;
    end else begin
      done <= 1'b0;
      if (ctrl.load) begin
        busy <= 1'b1;
        stepReg <= needOrient ? STEP_ORIENT : STEP_COLWIN;
      end else if (accept) begin
        if (stepReg == STEP_LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          stepReg <= stepReg + 1'b1;
        end
      end
    end
  end

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_after_memwr_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && $past(wordReady) && $past(stepReg) == STEP_LAST && !busy));
  assert_stall_holds_step_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy && !wordReady |=> busy && $stable(stepReg));
endmodule

// File: rtl/lcdWindowCmdGen.sv
module lcdWindowCmdGen
  import lcdWinPkg::*;
#(
  parameter int COORD_W = 8,
  parameter int PANEL_W = 176,
  parameter int PANEL_H = 220
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [COORD_W-1:0] xs,
  input  logic [COORD_W-1:0] ys,
  input  logic [COORD_W-1:0] xe,
  input  logic [COORD_W-1:0] ye,
  input  logic [1:0]         rot,
  input  logic               bgr,
  output logic               busy,
  output logic               done,
  output logic               wordValid,
  input  logic               wordReady,
  output logic [8:0]         word
);
  ctrlStrobes_t ctrl;
  logic needOrient;

  lcdWinControl i_control (
    .clk(clk), .rstN(rstN), .start(start), .needOrient(needOrient),
    .wordReady(wordReady), .ctrl(ctrl), .busy(busy), .done(done)
  );

  lcdWinDatapath #(.COORD_W(COORD_W), .PANEL_W(PANEL_W), .PANEL_H(PANEL_H)) i_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .xs(xs), .ys(ys), .xe(xe), .ye(ye),
    .rot(rot), .bgr(bgr), .needOrient(needOrient), .word(word)
  );

  assign wordValid = busy;

  assert_hold_word_R11: assert property (@(posedge clk) disable iff (!rstN)
    wordValid && !wordReady |=> wordValid && $stable(word));
  assert_memwr_is_command_R2: assert property (@(posedge clk) disable iff (!rstN)
    wordValid && word[7:0] == 8'h2C && word[8] == 1'b0 && wordReady |=> done);
endmodule

// File: tb/test_lcdWindowCmdGen.sv
`timescale 1ns/1ps
module test_lcdWindowCmdGen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] xs = 0, ys = 0, xe = 0, ye = 0;
  logic [1:0] rot = 0;
  logic bgr = 0;
  logic wordReady = 0;
  logic busy, done, wordValid;
  logic [8:0] word;

  int tests = 0, fails = 0;
  int cyc = 0;
  logic havePrev = 0;
  logic [1:0] prevRot;
  logic prevBgr;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lcdWindowCmdGen i_lcdWindowCmdGen (
    .clk(clk), .rstN(rstN), .start(start), .xs(xs), .ys(ys), .xe(xe), .ye(ye),
    .rot(rot), .bgr(bgr), .busy(busy), .done(done), .wordValid(wordValid),
    .wordReady(wordReady), .word(word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] clampv(input logic [7:0] v, input logic [7:0] m);
    return (v > m) ? m : v;
  endfunction

  // one burst; stallSeed shapes wordReady, interfere fires start while busy (R10)
  task automatic runBurst(input logic [7:0] ax, input logic [7:0] ay, input logic [7:0] bx,
                          input logic [7:0] by, input logic [1:0] r, input logic b,
                          input int stallSeed, input bit interfere);
    logic [8:0] exp [13];
    int n = 0;
    int got = 0;
    logic [7:0] xm, ym, op;
    logic orient;
    logic [8:0] held;
    logic wasStall = 0;
    xm = r[0] ? 8'd219 : 8'd175;
    ym = r[0] ? 8'd175 : 8'd219;
    orient = !havePrev || r != prevRot || b != prevBgr;
    if (orient) begin
      case (r)
        2'd0: op = 8'h00;
        2'd1: op = 8'hA0;
        2'd2: op = 8'hC0;
        default: op = 8'h60;
      endcase
      op[3] = b;
      exp[n++] = {1'b0, 8'h36};
      exp[n++] = {1'b1, op};
    end
    exp[n++] = {1'b0, 8'h2A}; exp[n++] = {1'b1, 8'h00}; exp[n++] = {1'b1, clampv(ax, xm)};
    exp[n++] = {1'b1, 8'h00}; exp[n++] = {1'b1, clampv(bx, xm)};
    exp[n++] = {1'b0, 8'h2B}; exp[n++] = {1'b1, 8'h00}; exp[n++] = {1'b1, clampv(ay, ym)};
    exp[n++] = {1'b1, 8'h00}; exp[n++] = {1'b1, clampv(by, ym)};
    exp[n++] = {1'b0, 8'h2C};
    havePrev = 1; prevRot = r; prevBgr = b;

    @(negedge clk);
    xs = ax; ys = ay; xe = bx; ye = by; rot = r; bgr = b; start = 1; wordReady = 0;
    @(negedge clk);
    start = 0;
    check("R8 busy after start", busy, 1);
    while (got < n) begin
      if (wasStall) check("R11 stalled word held", {wordValid, word}, {1'b1, held});
      check("R2 R3 R4 R5 R6 R7 R8 R9 word", {wordValid, word}, {1'b1, exp[got]});
      if (interfere && got == 3) begin
        xs = 8'd1; ye = 8'd2; rot = ~r; bgr = ~b; start = 1;
      end else start = 0;
      wordReady = ((got + stallSeed + cyc) % 3) != 0;
      wasStall = !wordReady;
      held = word;
      if (wordReady) got++;
      @(negedge clk);
    end
    start = 0; wordReady = 0;
    check("R12 done pulse", {done, busy}, 2'b10);
    @(negedge clk);
    check("R12 done single", done, 0);
    check("R10 no extra burst", {busy, wordValid}, 2'b00);
    rot = r; bgr = b;
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {busy, wordValid, done}, 3'b000);
    rstN = 1;
    @(negedge clk);
    check("R1 idle after reset", {busy, wordValid, done}, 3'b000);
    for (int r = 0; r < 4; r++)
      for (int b = 0; b < 2; b++) begin
        runBurst(8'd3, 8'd7, 8'd100, 8'd150, 2'(r), 1'(b), r + b, 0);
        runBurst(8'd176, 8'd180, 8'd219, 8'd220, 2'(r), 1'(b), r, 0);
        runBurst(8'd255, 8'd0, 8'd175, 8'd255, 2'(r), 1'(b), 1, 0);
      end
    runBurst(8'd10, 8'd20, 8'd30, 8'd40, 2'd1, 1'b0, 2, 1);
    runBurst(8'd10, 8'd20, 8'd30, 8'd40, 2'd1, 1'b0, 0, 0);
    runBurst(8'd0, 8'd0, 8'd0, 8'd0, 2'd3, 1'b1, 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule